// File: doc/BRIEF.md
# Global-History Correlating Branch Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters and a shift register with the outcomes of the most recent branches. Fetch presents a branch address and gets back a taken/not-taken guess in the same cycle. Fetch also gets a copy of the current history, which travels down the pipeline with the branch.

When the branch resolves, the back end returns the branch address, the real outcome and that history copy. The block then adjusts the one counter that the lookup used and shifts the outcome into the history register. After a misprediction the back end can also reload the history register from a saved copy.

A compile-time parameter picks how the counter index is formed from the address bits and the history:
- placing the history above the address bits, or
- XOR-ing the two together.

There is no tag, so branches whose index bits match share a counter.

Top module: `corr_bp`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken), so every lookup predicts not taken, and the history register reads all zeros.
- R2: `lk_taken` is the upper bit of the counter selected by `lk_pc` and the current history, with 1 meaning taken. It is combinational from `lk_pc` and reflects an update on the clock edge that performs it.
- R3: An update moves the selected counter up by one when the outcome is taken and down by one when not taken. The counter saturates at 3 and at 0.
- R4: With `MODE` = IDX_CONCAT, the index is {history, pc[PC_LSB +: PC_BITS]}, with the history in the upper bits.
- R5: With `MODE` = IDX_XOR, the index is pc[PC_LSB +: PC_BITS] XOR the zero-extended history.
- R6: An update locates its counter from `up_pc` and the snapshot `up_hist`, never from the live history register.
- R7: An update changes only the selected counter. Entries at other addresses or other history values keep their values.
- R8: On an update without restore, the history becomes {old history without its oldest bit, `up_taken`}. The newest outcome sits at bit 0, the oldest at the MSB, and 1 means taken.
- R9: A restore without an update loads `rs_hist` into the history register.
- R10: A restore together with an update loads `rs_hist` with `up_taken` shifted in at bit 0.
- R11: There is no address check. Addresses that differ only outside the indexed bits share one counter.
- R12: In a cycle with neither update nor restore, the history and every counter keep their values, so a repeated lookup gives the same answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | ADDR_W | Address of the branch being fetched |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_BITS | Current history, kept by fetch as the snapshot |
| up_valid | input | 1 | Resolved branch strobe |
| up_pc | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Real outcome, 1 = taken |
| up_hist | input | HIST_BITS | History snapshot taken at lookup |
| rs_valid | input | 1 | History restore strobe |
| rs_hist | input | HIST_BITS | History value to restore |

## Verification
The hardest case to reach from the ports is reading one chosen counter. The lookup always uses the live history, and every update shifts that history away from the value under test. The stimulus therefore follows each update with a restore-only cycle, which puts the history back to the snapshot under test before the address is looked up. The same method lets the bench show the following:
- an update with a stale snapshot trains the counter at the snapshot, not at the live history;
- two addresses that differ only above the index bits train the same counter.

// File: rtl/corr_pkg.sv
package corr_pkg;

    typedef enum logic {
        IDX_CONCAT = 1'b0,
        IDX_XOR    = 1'b1
    } idx_mode_e;

    localparam logic [1:0] CTR_WEAK_NT = 2'b01;

    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
        logic [1:0] nxt;
        nxt = cur;
        if (up && cur != 2'b11) nxt = cur + 2'd1;
        if (!up && cur != 2'b00) nxt = cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/corr_bp_index.sv
module corr_bp_index
    import corr_pkg::*;
#(
    parameter idx_mode_e MODE      = IDX_CONCAT,
    parameter int        ADDR_W    = 16,
    parameter int        PC_LSB    = 2,
    parameter int        PC_BITS   = 4,
    parameter int        HIST_BITS = 2,
    parameter int        IDX_W     = 6
) (
    input  logic [ADDR_W-1:0]    pc,
    input  logic [HIST_BITS-1:0] hist,
    output logic [IDX_W-1:0]     idx
);

    logic [PC_BITS-1:0] pc_field;
    logic               unused_pc_bits;

    assign pc_field       = pc[PC_LSB +: PC_BITS];
    assign unused_pc_bits = ^pc;

    generate
        if (MODE == IDX_CONCAT) begin : g_concat
            assign idx = {hist, pc_field};
        end else begin : g_xor
            assign idx = IDX_W'(pc_field) ^ IDX_W'(hist);
        end
    endgenerate

endmodule

// File: rtl/corr_bp_hist.sv
module corr_bp_hist #(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 shift_bit,
    input  logic                 load_en,
    input  logic [HIST_BITS-1:0] load_val,
    output logic [HIST_BITS-1:0] hist
);

    logic [HIST_BITS-1:0] hist_d, hist_q;
    logic [HIST_BITS-1:0] base;

    always_comb begin
        base   = load_en ? load_val : hist_q;
        hist_d = base;
        if (shift_en) hist_d = HIST_BITS'({base, shift_bit});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;

endmodule

// File: rtl/corr_bp_table.sv
module corr_bp_table
    import corr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [1:0] ctr_d [ENTRIES];
    logic [1:0] ctr_q [ENTRIES];

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_ctr
            always_comb begin
                ctr_d[i] = ctr_q[i];
                if (wr_en && wr_idx == IDX_W'(i)) ctr_d[i] = ctr_step(ctr_q[i], wr_taken);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) ctr_q[i] <= CTR_WEAK_NT;
                else        ctr_q[i] <= ctr_d[i];
            end
        end
    endgenerate

    assign rd_taken = ctr_q[rd_idx][1];

endmodule

// File: rtl/corr_bp.sv
module corr_bp
    import corr_pkg::*;
#(
    parameter idx_mode_e MODE      = IDX_CONCAT,
    parameter int        ADDR_W    = 16,
    parameter int        PC_LSB    = 2,
    parameter int        PC_BITS   = 4,
    parameter int        HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    lk_pc,
    output logic                 lk_taken,
    output logic [HIST_BITS-1:0] lk_hist,
    input  logic                 up_valid,
    input  logic [ADDR_W-1:0]    up_pc,
    input  logic                 up_taken,
    input  logic [HIST_BITS-1:0] up_hist,
    input  logic                 rs_valid,
    input  logic [HIST_BITS-1:0] rs_hist
);

    localparam int WIDE_W = (PC_BITS > HIST_BITS) ? PC_BITS : HIST_BITS;
    localparam int IDX_W  = (MODE == IDX_CONCAT) ? (PC_BITS + HIST_BITS) : WIDE_W;

    logic [IDX_W-1:0]     rd_idx, wr_idx;
    logic [HIST_BITS-1:0] hist_now;

    corr_bp_index #(
        .MODE(MODE), .ADDR_W(ADDR_W), .PC_LSB(PC_LSB),
        .PC_BITS(PC_BITS), .HIST_BITS(HIST_BITS), .IDX_W(IDX_W)
    ) u_rd_index (
        .pc(lk_pc), .hist(hist_now), .idx(rd_idx)
    );

    corr_bp_index #(
        .MODE(MODE), .ADDR_W(ADDR_W), .PC_LSB(PC_LSB),
        .PC_BITS(PC_BITS), .HIST_BITS(HIST_BITS), .IDX_W(IDX_W)
    ) u_wr_index (
        .pc(up_pc), .hist(up_hist), .idx(wr_idx)
    );

    corr_bp_hist #(
        .HIST_BITS(HIST_BITS)
    ) u_hist (
        .clk(clk), .rst_n(rst_n),
        .shift_en(up_valid), .shift_bit(up_taken),
        .load_en(rs_valid), .load_val(rs_hist),
        .hist(hist_now)
    );

    corr_bp_table #(
        .IDX_W(IDX_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_taken(lk_taken),
        .wr_en(up_valid), .wr_idx(wr_idx), .wr_taken(up_taken)
    );

    assign lk_hist = hist_now;

endmodule

// File: rtl/corr_bp_chk.sv
module corr_bp_chk #(
    parameter int ADDR_W    = 16,
    parameter int HIST_BITS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    lk_pc,
    input logic                 lk_taken,
    input logic [HIST_BITS-1:0] lk_hist,
    input logic                 up_valid,
    input logic                 up_taken,
    input logic                 rs_valid,
    input logic [HIST_BITS-1:0] rs_hist
);

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !rs_valid) |=> lk_hist == HIST_BITS'({$past(lk_hist), $past(up_taken)})); // R8

    AST_HIST_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !up_valid) |=> lk_hist == $past(rs_hist)); // R9

    AST_RESTORE_AND_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && up_valid) |=> lk_hist == HIST_BITS'({$past(rs_hist), $past(up_taken)})); // R10

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_valid && !up_valid) |=> $stable(lk_hist)); // R12

    AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!up_valid) && $stable(lk_pc) && $stable(lk_hist)) |-> $stable(lk_taken)); // R12

    AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(lk_taken)); // R2

endmodule

bind corr_bp corr_bp_chk #(
    .ADDR_W(ADDR_W), .HIST_BITS(HIST_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .up_valid(up_valid), .up_taken(up_taken),
    .rs_valid(rs_valid), .rs_hist(rs_hist)
);

// File: tb/corr_bp_bench.sv
module corr_bp_bench;
    import corr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lk_pc = '0;
    logic        sel_taken, xor_taken;
    logic [1:0]  sel_hist, xor_hist;
    logic        up_valid = 1'b0;
    logic [15:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [1:0]  up_hist = '0;
    logic        rs_valid = 1'b0;
    logic [1:0]  rs_hist = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    corr_bp u_corr_bp (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(sel_taken), .lk_hist(sel_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist),
        .rs_valid(rs_valid), .rs_hist(rs_hist)
    );

    corr_bp #(.MODE(IDX_XOR)) u_corr_bp_xor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(xor_taken), .lk_hist(xor_hist),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist),
        .rs_valid(rs_valid), .rs_hist(rs_hist)
    );

    typedef struct packed {
        logic [15:0] pc;
        logic [1:0]  snap;
        logic        taken;
        logic        exp_pred;
    } vec_t;

    // Gselect training sequence; counters start at 01.
    localparam vec_t VECS [13] = '{
        '{16'h0010, 2'b01, 1'b1, 1'b1},  // R3 01->10
        '{16'h0010, 2'b01, 1'b1, 1'b1},  // R3 10->11
        '{16'h0010, 2'b01, 1'b1, 1'b1},  // R3 saturate at 11
        '{16'h0010, 2'b01, 1'b0, 1'b1},  // R3 11->10
        '{16'h0010, 2'b01, 1'b0, 1'b0},  // R3 10->01
        '{16'h0010, 2'b01, 1'b0, 1'b0},  // R3 01->00
        '{16'h0010, 2'b01, 1'b0, 1'b0},  // R3 saturate at 00
        '{16'h0010, 2'b01, 1'b1, 1'b0},  // R3 00->01
        '{16'h0010, 2'b01, 1'b1, 1'b1},  // R3 01->10
        '{16'h0010, 2'b10, 1'b1, 1'b1},  // R4 other history, fresh counter
        '{16'h0010, 2'b10, 1'b0, 1'b0},  // R4
        '{16'h0014, 2'b01, 1'b1, 1'b1},  // R4 other address, fresh counter
        '{16'h0050, 2'b01, 1'b0, 1'b0}   // R11 aliases 0x0010/01: 10->01
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_upd(input logic [15:0] pc, input logic [1:0] snap, input logic t);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_hist = snap; up_taken = t;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic do_restore(input logic [1:0] h);
        @(negedge clk);
        rs_valid = 1'b1; rs_hist = h;
        @(negedge clk);
        rs_valid = 1'b0;
    endtask

    task automatic probe(input logic [15:0] pc);
        lk_pc = pc;
        #1;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        probe(16'h0000); chk("R1 pred", 16'(sel_taken), 16'd0);
        probe(16'h003C); chk("R1 pred", 16'(sel_taken), 16'd0);
        probe(16'h0014); chk("R1 pred xor", 16'(xor_taken), 16'd0);
        chk("R1 hist", 16'(sel_hist), 16'd0);

        // R8 history order, newest at bit 0
        do_upd(16'h003C, 2'b00, 1'b1); #1 chk("R8 hist", 16'(sel_hist), 16'b01);
        do_upd(16'h003C, 2'b01, 1'b0); #1 chk("R8 hist", 16'(sel_hist), 16'b10);
        do_upd(16'h003C, 2'b10, 1'b1); #1 chk("R8 hist", 16'(sel_hist), 16'b01);
        do_upd(16'h003C, 2'b01, 1'b1); #1 chk("R8 hist", 16'(sel_hist), 16'b11);
        // R9 restore alone
        do_restore(2'b10); #1 chk("R9 hist", 16'(sel_hist), 16'b10);
        // R10 restore with update
        @(negedge clk);
        rs_valid = 1'b1; rs_hist = 2'b01;
        up_valid = 1'b1; up_pc = 16'h003C; up_hist = 2'b11; up_taken = 1'b0;
        @(negedge clk);
        rs_valid = 1'b0; up_valid = 1'b0;
        #1 chk("R10 hist", 16'(sel_hist), 16'b10);

        // R5 gshare: pc 0x10 (0100) ^ 01 = 0101 equals pc 0x14 (0101) ^ 00
        do_upd(16'h0010, 2'b01, 1'b1);
        do_upd(16'h0010, 2'b01, 1'b1);
        do_restore(2'b00);
        probe(16'h0014);
        chk("R5 xor pred", 16'(xor_taken), 16'd1);
        chk("R4 concat pred", 16'(sel_taken), 16'd0);

        do_reset();
        // R7 only the selected counter moves
        do_upd(16'h0030, 2'b11, 1'b1);
        do_upd(16'h0030, 2'b11, 1'b1);
        do_restore(2'b11);
        probe(16'h0030); chk("R7 trained", 16'(sel_taken), 16'd1);
        probe(16'h0034); chk("R7 neighbour pc", 16'(sel_taken), 16'd0);
        do_restore(2'b10);
        probe(16'h0030); chk("R7 neighbour hist", 16'(sel_taken), 16'd0);

        // R6 snapshot, not live history, picks the counter
        do_restore(2'b11);
        do_upd(16'h0020, 2'b00, 1'b1);
        do_restore(2'b00);
        probe(16'h0020); chk("R6 snapshot entry", 16'(sel_taken), 16'd1);
        do_restore(2'b11);
        probe(16'h0020); chk("R6 live entry", 16'(sel_taken), 16'd0);

        // R2 R3 R4 R11 vector walk
        foreach (VECS[i]) begin
            do_upd(VECS[i].pc, VECS[i].snap, VECS[i].taken);
            do_restore(VECS[i].snap);
            probe(VECS[i].pc);
            chk($sformatf("R2 R3 vec %0d", i), 16'(sel_taken), 16'(VECS[i].exp_pred));
        end
        probe(16'h0010);
        chk("R11 alias", 16'(sel_taken), 16'd0);

        // R12 idle cycles change nothing
        probe(16'h0014);
        repeat (5) @(negedge clk);
        #1;
        chk("R12 pred", 16'(sel_taken), 16'd1);
        chk("R12 hist", 16'(sel_hist), 16'b01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule